// File: doc/BRIEF.md
# Echo Mixer Control Register Port

This block is the write-only control port that holds the configuration of an echo and mixer path. It decodes two serial protocols into one shared set of registers. The first is a three-wire bus made of a chip-enable line, a clock and a data line. The second is an I2C slave that shares the same clock and data pins.

The chip-enable line selects which protocol is in use. While it is low, the I2C slave is live, and an address byte for the three-wire bus can also be shifted in. While it is high, the I2C slave is held idle, and three-wire data bits are shifted in. A three-wire frame is committed when chip-enable falls. An I2C write is committed once its data byte completes.

All pins are sampled with the system clock. The outputs are the register fields, plus an acknowledge enable that drives the shared data pin low.

Top module: `echo_ctrl_regs`

## Requirements
- R1: After reset every field is zero: line_sel=0 (stereo), key_en=0, both mic gains 0, delay_code=0 (echo off), echo_gain=0, fb_gain=0, test_bits=0, and sda_oe=0.
- R2: With ce_i low, the I2C address byte 0x38 is acknowledged. That byte is the 7-bit address 0011100 followed by a read/write bit of 0. Any other address byte, including 0x39 (read), is not acknowledged, and the bytes that follow it change no field.
- R3: For an accepted byte, sda_oe rises after the falling clock edge that ends the 8th bit and stays high through the 9th clock pulse. It drops after the falling edge of the 9th clock, and it is 0 outside these acknowledge slots.
- R4: I2C sub-address 0x01: data bits [7:5] go to line_sel, bit 4 to key_en, and bits [2:0] to mic1_gain. Bit 3 is ignored.
- R5: I2C sub-address 0x02: data bits [7:5] go to mic2_gain, and bits [3:0] to test_bits.
- R6: I2C sub-address 0x03: data bits [7:5] go to delay_code, and bits [2:0] to echo_gain. Sub-address 0x04: data bits [7:5] go to fb_gain. Fields held under other sub-addresses keep their values.
- R7: A sub-address byte other than 0x01 to 0x04 is not acknowledged, and the data byte that follows it changes no field.
- R8: An I2C data byte updates its fields as soon as its 8th bit completes, whether or not a stop condition follows.
- R9: Three-wire group A is selected by address byte 0x38. The 16-bit data word is shifted MSB first: [15:13] line_sel, [12] key_en, [11:9] mic1_gain, [8:6] mic2_gain, [5:2] test_bits, [1:0] unused. It is committed on the falling edge of ce_i.
- R10: Three-wire group B is selected by address byte 0x39. The data word is laid out as [15:13] echo_gain, [12:10] delay_code, [9:7] fb_gain, [6:0] unused, and is committed the same way as group A.
- R11: A three-wire frame changes no field unless exactly 16 data bits were clocked in while ce_i was high and the address byte was 0x38 or 0x39.
- R12: While ce_i is high, I2C start conditions and bytes are ignored: sda_oe stays 0 and no field changes through I2C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_i | input | 1 | Chip enable: low selects I2C and the three-wire address phase, high selects the three-wire data phase |
| scl_i | input | 1 | Serial clock shared by both protocols |
| sda_i | input | 1 | Serial data shared by both protocols |
| sda_oe | output | 1 | Pulls the data pin low to acknowledge an I2C byte |
| line_sel | output | 3 | Line output selection code |
| key_en | output | 1 | External key control enable |
| mic1_gain | output | 3 | Microphone 1 gain code |
| mic2_gain | output | 3 | Microphone 2 gain code |
| test_bits | output | 4 | Test field, expected to be written as zero |
| delay_code | output | 3 | Echo delay code |
| echo_gain | output | 3 | Echo output gain code |
| fb_gain | output | 3 | Echo feedback gain code |

## Verification
The hardest state to reach from the ports is the exchange of the shared pins between the two protocols. A three-wire frame must not be taken for an I2C start, and I2C traffic sent while chip-enable is high must not leave a frame that gets committed when chip-enable falls. The stimulus sends complete I2C transactions with chip-enable held high and then drops it, so the bit counter holds a count other than 16 at that falling edge. It also sends three-wire frames of 15 and 17 bits, and a frame with a foreign address byte. Every data change is placed in the low phase of the clock, so that only deliberate start and stop conditions appear.

// File: rtl/echo_ctrl_regs.sv
module echo_ctrl_regs #(
  parameter logic [6:0] DEV_ADDR = 7'b0011100,
  parameter logic [7:0] GRP_A    = 8'h38,
  parameter logic [7:0] GRP_B    = 8'h39
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [2:0] line_sel,
  output logic       key_en,
  output logic [2:0] mic1_gain,
  output logic [2:0] mic2_gain,
  output logic [3:0] test_bits,
  output logic [2:0] delay_code,
  output logic [2:0] echo_gain,
  output logic [2:0] fb_gain
);
  localparam int FRAME_BITS = 16;
  localparam int CW = $clog2(FRAME_BITS + 2);

  typedef enum logic [1:0] {P_IDLE, P_ADDR, P_SUB, P_DATA} phase_t;

  logic [2:0] ce_q, scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q  <= '0;
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      ce_q  <= {ce_q[1:0], ce_i};
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  logic ce, ce_rise, ce_fall, scl_rise, scl_fall, bit_in, start_c, stop_c;
  assign ce       = ce_q[1];
  assign ce_rise  = ce_q[1] & ~ce_q[2];
  assign ce_fall  = ~ce_q[1] & ce_q[2];
  assign scl_rise = scl_q[1] & ~scl_q[2];
  assign scl_fall = ~scl_q[1] & scl_q[2];
  assign bit_in   = sda_q[1];
  assign start_c  = ~ce & scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  assign stop_c   = ~ce & scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];

  // three-wire path
  logic [7:0]    tw_addr;
  logic [15:0]   tw_data;
  logic [CW-1:0] tw_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tw_addr <= '0;
      tw_data <= '0;
      tw_cnt  <= '0;
    end else if (ce_rise) begin
      tw_cnt <= '0;
    end else if (scl_rise) begin
      if (ce) begin
        tw_data <= {tw_data[14:0], bit_in};
        if (tw_cnt != '1) tw_cnt <= tw_cnt + 1'b1;
      end else begin
        tw_addr <= {tw_addr[6:0], bit_in};
      end
    end
  end

  logic tw_ok, tw_we_a, tw_we_b;
  assign tw_ok   = ce_fall && (tw_cnt == CW'(FRAME_BITS));
  assign tw_we_a = tw_ok && (tw_addr == GRP_A);
  assign tw_we_b = tw_ok && (tw_addr == GRP_B);

  // I2C path
  phase_t     ph;
  logic [7:0] sh;
  logic [3:0] bc;
  logic [2:0] sub_q;
  logic       in_ack, ack_q;

  logic sub_ok, byte_done;
  assign sub_ok    = (sh[7:3] == 5'd0) && (sh[2:0] != 3'd0) && (sh[2:0] <= 3'd4);
  assign byte_done = scl_fall && (bc == 4'd8) && !in_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= P_IDLE; sh <= '0; bc <= '0; sub_q <= '0; in_ack <= 1'b0; ack_q <= 1'b0;
    end else if (ce || stop_c) begin
      ph <= P_IDLE; in_ack <= 1'b0; ack_q <= 1'b0;
    end else if (start_c) begin
      ph <= P_ADDR; bc <= '0; in_ack <= 1'b0; ack_q <= 1'b0;
    end else if (ph != P_IDLE) begin
      if (in_ack) begin
        if (scl_fall) begin
          in_ack <= 1'b0; ack_q <= 1'b0; bc <= '0;
        end
      end else if (scl_rise && bc != 4'd8) begin
        sh <= {sh[6:0], bit_in};
        bc <= bc + 1'b1;
      end else if (byte_done) begin
        case (ph)
          P_ADDR:
            if (sh == {DEV_ADDR, 1'b0}) begin
              ack_q <= 1'b1; in_ack <= 1'b1; ph <= P_SUB;
            end else ph <= P_IDLE;
          P_SUB:
            if (sub_ok) begin
              sub_q <= sh[2:0]; ack_q <= 1'b1; in_ack <= 1'b1; ph <= P_DATA;
            end else ph <= P_IDLE;
          default: begin
            ack_q <= 1'b1; in_ack <= 1'b1;
          end
        endcase
      end
    end
  end

  logic i2c_we;
  assign i2c_we = !ce && !start_c && !stop_c && (ph == P_DATA) && byte_done;
  assign sda_oe = ack_q;

  // register file
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_sel <= '0; key_en <= 1'b0; mic1_gain <= '0; mic2_gain <= '0;
      test_bits <= '0; delay_code <= '0; echo_gain <= '0; fb_gain <= '0;
    end else if (tw_we_a) begin
      line_sel  <= tw_data[15:13];
      key_en    <= tw_data[12];
      mic1_gain <= tw_data[11:9];
      mic2_gain <= tw_data[8:6];
      test_bits <= tw_data[5:2];
    end else if (tw_we_b) begin
      echo_gain  <= tw_data[15:13];
      delay_code <= tw_data[12:10];
      fb_gain    <= tw_data[9:7];
    end else if (i2c_we) begin
      case (sub_q)
        3'd1: begin line_sel <= sh[7:5]; key_en <= sh[4]; mic1_gain <= sh[2:0]; end
        3'd2: begin mic2_gain <= sh[7:5]; test_bits <= sh[3:0]; end
        3'd3: begin delay_code <= sh[7:5]; echo_gain <= sh[2:0]; end
        default: fb_gain <= sh[7:5];
      endcase
    end
  end

  logic any_we;
  logic [22:0] cfg_vec;
  assign any_we  = tw_we_a | tw_we_b | i2c_we;
  assign cfg_vec = {line_sel, key_en, mic1_gain, mic2_gain, test_bits, delay_code, echo_gain, fb_gain};

  assert_fields_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(any_we) |-> $stable(cfg_vec));

  assert_no_ack_ce_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_q[2] && $past(ce_q[2])) |-> !sda_oe);

  assert_ack_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> in_ack);

  assert_ack_on_low_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q[1]);

  assert_one_writer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(i2c_we && (tw_we_a || tw_we_b)));
endmodule

// File: tb/echo_ctrl_regs_bench.sv
module echo_ctrl_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, scl = 1'b1, sda = 1'b1;
  logic sda_oe, key_en;
  logic [2:0] line_sel, mic1_gain, mic2_gain, delay_code, echo_gain, fb_gain;
  logic [3:0] test_bits;

  always #2.5 clk = ~clk;

  echo_ctrl_regs u_echo_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .line_sel(line_sel), .key_en(key_en), .mic1_gain(mic1_gain), .mic2_gain(mic2_gain),
    .test_bits(test_bits), .delay_code(delay_code), .echo_gain(echo_gain), .fb_gain(fb_gain));

  localparam int H = 8;
  int errors = 0, checks = 0;
  logic [2:0] e_line = 0, e_mic1 = 0, e_mic2 = 0, e_dly = 0, e_echo = 0, e_fb = 0;
  logic e_key = 0;
  logic [3:0] e_test = 0;

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk(tag, {9'd0, line_sel, key_en, mic1_gain, mic2_gain, test_bits, delay_code, echo_gain, fb_gain},
             {9'd0, e_line, e_key, e_mic1, e_mic2, e_test, e_dly, e_echo, e_fb});
  endtask

  task automatic i2c_start;
    sda = 1; w(H); scl = 1; w(H); sda = 0; w(H); scl = 0; w(H);
  endtask

  task automatic i2c_stop;
    sda = 0; w(H); scl = 1; w(H); sda = 1; w(H);
  endtask

  task automatic i2c_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda = b[i]; w(H); scl = 1; w(H); scl = 0; w(H);
    end
    sda = 1; w(H); scl = 1; w(H/2); ack = sda_oe; w(H/2); scl = 0; w(H);
  endtask

  task automatic i2c_write(input logic [7:0] sub, input logic [7:0] d, output logic a0, a1, a2);
    i2c_start;
    i2c_byte(8'h38, a0);
    i2c_byte(sub, a1);
    i2c_byte(d, a2);
    i2c_stop;
  endtask

  task automatic tw_write(input logic [7:0] a, input logic [31:0] d, input int n);
    scl = 0; w(H);
    for (int i = 7; i >= 0; i--) begin
      sda = a[i]; w(H); scl = 1; w(H); scl = 0;
    end
    w(H); ce = 1; w(H);
    for (int i = 0; i < n; i++) begin
      sda = d[31-i]; w(H); scl = 1; w(H); scl = 0;
    end
    w(H); ce = 0; w(H); sda = 1; w(H); scl = 1; w(2*H);
  endtask

  task automatic t_reset;
    chk_regs("R1 reset fields");
    chk("R1 reset sda_oe", {31'd0, sda_oe}, 32'd0);
  endtask

  task automatic t_sub1;
    logic a0, a1, a2;
    i2c_write(8'h01, 8'hBB, a0, a1, a2);
    e_line = 3'd5; e_key = 1; e_mic1 = 3'd3;
    chk("R2 address ack", {31'd0, a0}, 32'd1);
    chk("R3 sub and data ack", {30'd0, a1, a2}, 32'd3);
    chk("R3 released after byte", {31'd0, sda_oe}, 32'd0);
    chk_regs("R4 sub 01 fields");
  endtask

  task automatic t_sub2;
    logic a0, a1, a2;
    i2c_write(8'h02, 8'hCA, a0, a1, a2);
    e_mic2 = 3'd6; e_test = 4'hA;
    chk_regs("R5 sub 02 fields");
  endtask

  task automatic t_sub34;
    logic a0, a1, a2;
    i2c_write(8'h03, 8'h65, a0, a1, a2);
    e_dly = 3'd3; e_echo = 3'd5;
    chk_regs("R6 sub 03 fields");
    i2c_write(8'h04, 8'hE0, a0, a1, a2);
    e_fb = 3'd7;
    chk_regs("R6 sub 04 fields");
  endtask

  task automatic t_bad_addr;
    logic a0, a1, a2;
    i2c_start; i2c_byte(8'h39, a0); i2c_byte(8'h01, a1); i2c_byte(8'h00, a2); i2c_stop;
    chk("R2 read address nack", {29'd0, a0, a1, a2}, 32'd0);
    i2c_start; i2c_byte(8'h3A, a0); i2c_byte(8'h01, a1); i2c_byte(8'h00, a2); i2c_stop;
    chk("R2 foreign address nack", {29'd0, a0, a1, a2}, 32'd0);
    chk_regs("R2 no change after nack");
  endtask

  task automatic t_bad_sub;
    logic a0, a1, a2;
    i2c_write(8'h05, 8'h00, a0, a1, a2);
    chk("R7 sub 05 nack", {30'd0, a1, a2}, 32'd0);
    i2c_write(8'h00, 8'h00, a0, a1, a2);
    chk("R7 sub 00 nack", {30'd0, a1, a2}, 32'd0);
    chk_regs("R7 no change");
  endtask

  task automatic t_no_stop;
    logic a0, a1, a2;
    i2c_start; i2c_byte(8'h38, a0); i2c_byte(8'h01, a1); i2c_byte(8'h40, a2);
    e_line = 3'd2; e_key = 0; e_mic1 = 3'd0;
    chk_regs("R8 update before stop");
    i2c_start; i2c_byte(8'h38, a0); i2c_byte(8'h03, a1); i2c_byte(8'h21, a2);
    e_dly = 3'd1; e_echo = 3'd1;
    chk_regs("R8 update after repeated start");
    i2c_stop;
  endtask

  task automatic t_ce_high;
    logic a0, a1, a2;
    ce = 1; w(2*H);
    i2c_write(8'h01, 8'hFF, a0, a1, a2);
    chk("R12 no ack with ce high", {29'd0, a0, a1, a2}, 32'd0);
    scl = 0; w(H); ce = 0; w(H); scl = 1; w(2*H);
    chk_regs("R12 no change with ce high");
  endtask

  task automatic t_tw_a;
    tw_write(8'h38, {16'h95C0, 16'h0}, 16);
    e_line = 3'd4; e_key = 1; e_mic1 = 3'd2; e_mic2 = 3'd7; e_test = 4'd0;
    chk_regs("R9 group A frame");
  endtask

  task automatic t_tw_b;
    tw_write(8'h39, {16'hC880, 16'h0}, 16);
    e_echo = 3'd6; e_dly = 3'd2; e_fb = 3'd1;
    chk_regs("R10 group B frame");
  endtask

  task automatic t_tw_bad;
    tw_write(8'h38, {16'hFFFF, 16'h0}, 15);
    chk_regs("R11 short frame ignored");
    tw_write(8'h38, {16'hFFFF, 16'hFFFF}, 17);
    chk_regs("R11 long frame ignored");
    tw_write(8'h3A, {16'hFFFF, 16'h0}, 16);
    chk_regs("R11 foreign address ignored");
  endtask

  initial begin
    w(4); rst_n = 1; w(4);
    t_reset;
    t_sub1;
    t_sub2;
    t_sub34;
    t_bad_addr;
    t_bad_sub;
    t_no_stop;
    t_ce_high;
    t_tw_a;
    t_tw_b;
    t_tw_bad;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #900000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule